// File: doc/BRIEF.md
# Multi-Driver Net Strength Resolver

This combinational block models how a shared wire settles when several sources drive it at once. Each of the `N` driver ports has an enable, a logic value, a configured flag, a pull-type flag and two 3-bit strength codes. One code applies when the driver drives 0 and the other when it drives 1. The block finds the strongest active contribution. The strongest driver sets the net's value and strength. If the top strength is shared by drivers that disagree, the net goes to X at that strength. If nothing drives the net, it floats at high impedance.

Beside the numeric result, the block produces a three-character ASCII tag for logging and display. The tag is a two-letter strength mnemonic followed by a value character. A driver whose configuration is illegal, with both strengths at high impedance, is reported on a per-driver error bit and is left out of resolution.

Top module: `nsr_resolver`

## Requirements
- R1: Strength levels are 3-bit codes: 7 supply, 6 strong, 5 pull, 4 large, 3 weak, 2 medium, 1 small, 0 high impedance. Driver `i` uses bits `[3*i+2:3*i]` of `drv_s0` and `drv_s1`.
- R2: A driver driving 1 contributes its 1-strength, and a driver driving 0 contributes its 0-strength.
- R3: With no active driver, `res_val` is 2 (Z), `res_lvl` is 0 and the tag is "HiZ". The value encoding is 0 = logic 0, 1 = logic 1, 2 = Z, 3 = X.
- R4: With a single active driver, `res_val` and `res_lvl` equal that driver's value and selected strength.
- R5: With several active drivers, `res_lvl` is the greatest selected strength, and `res_val` is the value of the drivers at that strength.
- R6: When active drivers at the greatest strength disagree in value, `res_val` is 3 (X) and `res_lvl` is that strength.
- R7: A driver with `drv_cfg` low ignores its strength codes. It uses strong (6) for both values, or pull (5) for both values when its `drv_pull` bit is high.
- R8: A driver with `drv_cfg` high and both strength codes 0 raises its `cfg_err` bit, whether or not it is enabled, and takes no part in resolution.
- R9: A driver whose selected strength is 0 is treated as inactive and contributes Z.
- R10: A driver that is disabled, or whose value bit is X or Z, is treated as driving nothing.
- R11: `res_tag` holds three ASCII characters, first character in bits `[23:16]`. The first two characters are the mnemonic (Su, St, Pu, La, We, Me, Sm, Hi for levels 7 down to 0). The third is '0', '1', 'X' or 'Z'.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| drv_en | input | N | Per-driver enable |
| drv_val | input | N | Per-driver logic value |
| drv_cfg | input | N | High: use the given strength codes; low: use a default strength |
| drv_pull | input | N | When unconfigured, selects the pull default instead of strong |
| drv_s0 | input | 3*N | Per-driver strength used when driving 0 |
| drv_s1 | input | 3*N | Per-driver strength used when driving 1 |
| res_val | output | 2 | Resolved value: 0, 1, 2 = Z, 3 = X |
| res_lvl | output | 3 | Resolved strength level |
| res_tag | output | 24 | ASCII mnemonic and value character |
| cfg_err | output | N | Per-driver illegal-configuration flag |

## Verification
The hardest case to reach from the ports is a tie at the top strength between drivers with different values, while weaker drivers are also active and would decide the result if the tie logic were wrong. Random stimulus rarely produces such a tie at supply level together with a lower-level contender. Directed vectors therefore place equal-strength opposite drivers next to weaker ones. The random phase narrows strength codes to a small set so that ties and exclusions occur often.

// File: rtl/nsr_pkg.sv
package nsr_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_HIGHZ  = 3'd0;
  localparam lvl_t LVL_PULL   = 3'd5;
  localparam lvl_t LVL_STRONG = 3'd6;

  typedef enum logic [1:0] {
    NV_ZERO = 2'd0,
    NV_ONE  = 2'd1,
    NV_Z    = 2'd2,
    NV_X    = 2'd3
  } netval_e;

  // Two-letter mnemonic for a strength level, first letter in the high byte.
  function automatic logic [15:0] lvl_mnemonic(input lvl_t lvl);
    logic [15:0] m;
    case (lvl)
      3'd7:    m = {8'h53, 8'h75}; // Su
      3'd6:    m = {8'h53, 8'h74}; // St
      3'd5:    m = {8'h50, 8'h75}; // Pu
      3'd4:    m = {8'h4C, 8'h61}; // La
      3'd3:    m = {8'h57, 8'h65}; // We
      3'd2:    m = {8'h4D, 8'h65}; // Me
      3'd1:    m = {8'h53, 8'h6D}; // Sm
      default: m = {8'h48, 8'h69}; // Hi
    endcase
    return m;
  endfunction

  function automatic logic [7:0] val_char(input netval_e v);
    logic [7:0] c;
    case (v)
      NV_ZERO: c = 8'h30;
      NV_ONE:  c = 8'h31;
      NV_X:    c = 8'h58;
      default: c = 8'h5A;
    endcase
    return c;
  endfunction

  // Strength that applies for a given value, given the two configured codes.
  function automatic lvl_t pick_strength(input logic v, input lvl_t s0, input lvl_t s1);
    return v ? s1 : s0;
  endfunction

  // Combine the presence of 0s and 1s at the top level into a net value.
  function automatic netval_e merge_value(input logic any_act, input logic has0, input logic has1);
    netval_e r;
    if (!any_act)          r = NV_Z;
    else if (has0 && has1) r = NV_X;
    else if (has1)         r = NV_ONE;
    else                   r = NV_ZERO;
    return r;
  endfunction
endpackage

// File: rtl/nsr_driver_prep.sv
module nsr_driver_prep
  import nsr_pkg::*;
(
  input  logic en,
  input  logic val,
  input  logic cfg,
  input  logic pull,
  input  lvl_t s0,
  input  lvl_t s1,
  output logic active,
  output logic val_bit,
  output lvl_t lvl,
  output logic illegal
);
  lvl_t eff0, eff1, sel;
  logic known;
  logic dflt_sel;

  always_comb begin
    dflt_sel = ~cfg;
    illegal  = cfg && (s0 == LVL_HIGHZ) && (s1 == LVL_HIGHZ);
    if (dflt_sel) begin
      eff0 = pull ? LVL_PULL : LVL_STRONG;
      eff1 = pull ? LVL_PULL : LVL_STRONG;
    end else begin
      eff0 = s0;
      eff1 = s1;
    end
    known   = (val === 1'b0) || (val === 1'b1);
    val_bit = known ? val : 1'b0;
    sel     = pick_strength(val_bit, eff0, eff1);
    active  = en && known && !illegal && (sel != LVL_HIGHZ);
    lvl     = active ? sel : LVL_HIGHZ;
  end

  always_comb begin
    if (!$isunknown({en, cfg, pull, s0, s1})) begin
      a_r8_illegal_excluded: assert (!(illegal && active));
      a_r9_zero_strength_idle: assert (!active || (lvl != LVL_HIGHZ));
      a_r7_default_strength: assert (cfg || !active || (lvl == (pull ? LVL_PULL : LVL_STRONG)));
    end
  end
endmodule

// File: rtl/nsr_max_find.sv
module nsr_max_find
  import nsr_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N*LVL_W-1:0] lvl_flat,
  input  logic [N-1:0]       act,
  input  logic [N-1:0]       vals,
  output lvl_t               max_lvl,
  output logic               any_act,
  output logic               has0,
  output logic               has1
);
  logic [N-1:0] at_top;

  always_comb begin
    max_lvl = LVL_HIGHZ;
    for (int i = 0; i < N; i++) begin
      if (act[i] && (lvl_flat[i*LVL_W +: LVL_W] > max_lvl))
        max_lvl = lvl_flat[i*LVL_W +: LVL_W];
    end
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_top
      assign at_top[g] = act[g] && (lvl_flat[g*LVL_W +: LVL_W] == max_lvl);
    end
  endgenerate

  assign any_act = |act;
  assign has0    = |(at_top & ~vals);
  assign has1    = |(at_top & vals);

  always_comb begin
    if (!$isunknown({lvl_flat, act, vals})) begin
      a_r3_idle_level_zero: assert (any_act || (max_lvl == LVL_HIGHZ));
      a_r5_some_driver_on_top: assert (!any_act || (at_top != '0));
      for (int i = 0; i < N; i++) begin
        a_r5_none_above_top: assert (!act[i] || (lvl_flat[i*LVL_W +: LVL_W] <= max_lvl));
      end
    end
  end
endmodule

// File: rtl/nsr_tag_fmt.sv
module nsr_tag_fmt
  import nsr_pkg::*;
(
  input  lvl_t        lvl,
  input  netval_e     val,
  output logic [23:0] tag
);
  assign tag = {lvl_mnemonic(lvl), val_char(val)};

  always_comb begin
    if (!$isunknown({lvl, val})) begin
      a_r11_value_char: assert (tag[7:0] inside {8'h30, 8'h31, 8'h58, 8'h5A});
      a_r11_hiz_pairing: assert ((val != NV_Z) || (tag[23:8] == {8'h48, 8'h69}));
    end
  end
endmodule

// File: rtl/nsr_resolver.sv
module nsr_resolver
  import nsr_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]       drv_en,
  input  logic [N-1:0]       drv_val,
  input  logic [N-1:0]       drv_cfg,
  input  logic [N-1:0]       drv_pull,
  input  logic [3*N-1:0]     drv_s0,
  input  logic [3*N-1:0]     drv_s1,
  output logic [1:0]         res_val,
  output logic [2:0]         res_lvl,
  output logic [23:0]        res_tag,
  output logic [N-1:0]       cfg_err
);
  localparam int FLAT_W = N * LVL_W;

  logic [N-1:0]      act;
  logic [N-1:0]      vbit;
  logic [FLAT_W-1:0] lvl_flat;
  lvl_t              top_lvl;
  logic              any_act, has0, has1;
  netval_e           merged;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_drv
      nsr_driver_prep u_prep (
        .en      (drv_en[g]),
        .val     (drv_val[g]),
        .cfg     (drv_cfg[g]),
        .pull    (drv_pull[g]),
        .s0      (drv_s0[g*LVL_W +: LVL_W]),
        .s1      (drv_s1[g*LVL_W +: LVL_W]),
        .active  (act[g]),
        .val_bit (vbit[g]),
        .lvl     (lvl_flat[g*LVL_W +: LVL_W]),
        .illegal (cfg_err[g])
      );
    end
  endgenerate

  nsr_max_find #(.N(N)) u_max (
    .lvl_flat (lvl_flat),
    .act      (act),
    .vals     (vbit),
    .max_lvl  (top_lvl),
    .any_act  (any_act),
    .has0     (has0),
    .has1     (has1)
  );

  assign merged  = merge_value(any_act, has0, has1);
  assign res_val = merged;
  assign res_lvl = top_lvl;

  nsr_tag_fmt u_fmt (
    .lvl (top_lvl),
    .val (merged),
    .tag (res_tag)
  );

  always_comb begin
    if (!$isunknown({drv_en, drv_cfg, drv_pull, drv_s0, drv_s1})) begin
      a_r3_idle_gives_z: assert (any_act || ((res_val == NV_Z) && (res_lvl == LVL_HIGHZ)));
      a_r6_conflict_gives_x: assert (!(has0 && has1) || (res_val == NV_X));
      a_r4_driven_level_nonzero: assert (!any_act || (res_lvl != LVL_HIGHZ));
      a_r8_err_bit_not_active: assert ((cfg_err & act) == '0);
    end
  end
endmodule

// File: tb/sim_nsr_resolver.sv
module sim_nsr_resolver;
  localparam int N = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0]   drv_en, drv_val, drv_cfg, drv_pull;
  logic [3*N-1:0] drv_s0, drv_s1;
  logic [1:0]     res_val;
  logic [2:0]     res_lvl;
  logic [23:0]    res_tag;
  logic [N-1:0]   cfg_err;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  nsr_resolver #(.N(N)) u0 (
    .drv_en(drv_en), .drv_val(drv_val), .drv_cfg(drv_cfg), .drv_pull(drv_pull),
    .drv_s0(drv_s0), .drv_s1(drv_s1), .res_val(res_val), .res_lvl(res_lvl),
    .res_tag(res_tag), .cfg_err(cfg_err)
  );

  // Independent model: per driver, pick strength, keep track of the best.
  int         e_val;
  int         e_lvl;
  logic [N-1:0] e_err;

  function automatic string mnem(input int l);
    case (l)
      7: return "Su"; 6: return "St"; 5: return "Pu"; 4: return "La";
      3: return "We"; 2: return "Me"; 1: return "Sm"; default: return "Hi";
    endcase
  endfunction

  function automatic string vch(input int v);
    case (v)
      0: return "0"; 1: return "1"; 3: return "X"; default: return "Z";
    endcase
  endfunction

  task automatic model();
    int best;
    bit saw0, saw1;
    best = 0; saw0 = 0; saw1 = 0;
    for (int i = 0; i < N; i++) begin
      int a, b, s;
      bit bad;
      bad = drv_cfg[i] && drv_s0[3*i +: 3] == 0 && drv_s1[3*i +: 3] == 0;
      e_err[i] = bad;
      if (drv_cfg[i]) begin a = drv_s0[3*i +: 3]; b = drv_s1[3*i +: 3]; end
      else begin a = drv_pull[i] ? 5 : 6; b = a; end
      if (!drv_en[i] || bad || $isunknown(drv_val[i])) continue;
      s = (drv_val[i] == 1'b1) ? b : a;
      if (s == 0) continue;
      if (s > best) begin best = s; saw0 = 0; saw1 = 0; end
      if (s == best) begin
        if (drv_val[i] == 1'b1) saw1 = 1; else saw0 = 0 | 1;
      end
    end
    e_lvl = best;
    if (best == 0) e_val = 2;
    else if (saw0 && saw1) e_val = 3;
    else if (saw1) e_val = 1;
    else e_val = 0;
  endtask

  task automatic check(input string req);
    string got, exp;
    model();
    got = $sformatf("%s", res_tag);
    exp = {mnem(e_lvl), vch(e_val)};
    compared++;
    if (res_val !== e_val[1:0] || res_lvl !== e_lvl[2:0] || got != exp || cfg_err !== e_err) begin
      mismatched++;
      $display("FAIL %s: got val=%0d lvl=%0d tag=%s err=%b, expected val=%0d lvl=%0d tag=%s err=%b",
               req, res_val, res_lvl, got, cfg_err, e_val, e_lvl, exp, e_err);
    end
  endtask

  task automatic clear();
    drv_en = '0; drv_val = '0; drv_cfg = '1; drv_pull = '0;
    drv_s0 = {N{3'd6}}; drv_s1 = {N{3'd6}};
  endtask

  task automatic setd(input int i, input bit v, input int s0, input int s1);
    drv_en[i] = 1'b1; drv_val[i] = v; drv_cfg[i] = 1'b1;
    drv_s0[3*i +: 3] = s0[2:0]; drv_s1[3*i +: 3] = s1[2:0];
  endtask

  task automatic apply_and_check(input string req);
    @(posedge clk);
    @(negedge clk);
    check(req);
  endtask

  task automatic expect_tag(input string req, input string want);
    string got;
    got = $sformatf("%s", res_tag);
    compared++;
    if (got != want) begin
      mismatched++;
      $display("FAIL %s: tag actual=%s expected=%s", req, got, want);
    end
  endtask

  initial begin
    clear();
    apply_and_check("R3 idle");
    expect_tag("R3 idle tag", "HiZ");

    // Four contention cases: first driver (supply1, weak0), second (pull1, supply0).
    clear(); setd(0, 0, 3, 7); setd(1, 0, 7, 5);
    apply_and_check("R5 weak0 vs supply0"); expect_tag("R11 Su0", "Su0");
    clear(); setd(0, 0, 3, 7); setd(1, 1, 7, 5);
    apply_and_check("R2 weak0 vs pull1"); expect_tag("R11 Pu1", "Pu1");
    clear(); setd(0, 1, 3, 7); setd(1, 0, 7, 5);
    apply_and_check("R6 supply tie"); expect_tag("R6 SuX", "SuX");
    clear(); setd(0, 1, 3, 7); setd(1, 1, 7, 5);
    apply_and_check("R5 supply1 vs pull1"); expect_tag("R11 Su1", "Su1");

    // Tie at top beside a weaker contender.
    clear(); setd(0, 1, 1, 6); setd(1, 0, 6, 1); setd(2, 1, 2, 3);
    apply_and_check("R6 tie with weaker"); expect_tag("R6 StX", "StX");

    clear(); setd(2, 1, 0, 4);
    apply_and_check("R4 single driver"); expect_tag("R1 La1", "La1");

    clear(); drv_en[1] = 1; drv_val[1] = 1; drv_cfg[1] = 0; drv_s1[5:3] = 3'd1;
    apply_and_check("R7 default strong"); expect_tag("R7 St1", "St1");
    drv_pull[1] = 1; setd(0, 0, 3, 3);
    apply_and_check("R7 default pull"); expect_tag("R7 Pu1", "Pu1");

    clear(); setd(3, 1, 0, 0); setd(0, 0, 1, 7);
    apply_and_check("R8 illegal excluded"); expect_tag("R8 Sm0", "Sm0");
    drv_en[3] = 0;
    apply_and_check("R8 flag when disabled");

    clear(); setd(0, 1, 7, 0); setd(1, 0, 2, 7);
    apply_and_check("R9 zero strength idle"); expect_tag("R9 Me0", "Me0");

    clear(); setd(0, 1, 7, 7); drv_val[0] = 1'bx; setd(1, 0, 3, 3);
    apply_and_check("R10 unknown value");
    clear(); setd(0, 1, 7, 7); drv_en[0] = 0;
    apply_and_check("R10 disabled"); expect_tag("R10 HiZ", "HiZ");

    // Random phase: strength codes from a narrow set to force ties.
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 600; k++) begin
      for (int i = 0; i < N; i++) begin
        int pick0, pick1;
        drv_en[i]   = ($urandom % 4) != 0;
        drv_val[i]  = $urandom % 2;
        drv_cfg[i]  = ($urandom % 6) != 0;
        drv_pull[i] = $urandom % 2;
        pick0 = ($urandom % 3 == 0) ? 0 : (($urandom % 2) ? 7 : 5 + $urandom % 2);
        pick1 = ($urandom % 3 == 0) ? 0 : (($urandom % 2) ? 7 : $urandom % 8);
        drv_s0[3*i +: 3] = pick0[2:0];
        drv_s1[3*i +: 3] = pick1[2:0];
      end
      apply_and_check("R5 R6 random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule